// File: doc/BRIEF.md
# ADC Channel-Switch Sequencer

This block is an SPI master for a multi-channel successive-approximation ADC. The ADC runs on its own internal conversion trigger and is set to manual channel selection. While automatic triggering is active, the converter ignores a plain channel-select command. For that reason the sequencer wraps every channel change in a trigger-mode toggle of the converter's configuration register. It sends three frames back to back: a configuration write with manual trigger, a channel select, and a configuration write with automatic trigger restored. Outside a switch it sends read commands continuously and returns each 16-bit result with a one-cycle valid strobe.

Software-facing logic supplies four inputs: a 12-bit base configuration, a run enable, a requested channel number and a change strobe. The sequencer forces the trigger-mode bit at the position given by `TRIG_BIT` and copies every other configuration bit from the base input. If a change request arrives while a frame is on the wire, the request is held pending. The latest request is served once the current frame, or the current three-frame switch, has finished.

Top module: `adc_chsw_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `cs_n` is 1, `sclk` is 0 and `result_valid` is 0. No frame starts while `run_en` is 0.
- R2: Each frame holds `cs_n` low for exactly 16 SCLK rising edges. `sclk` idles at 0 whenever `cs_n` is high. Each high phase of SCLK lasts exactly `HALF_DIV` clock cycles.
- R3: Between two frames, `cs_n` stays high for at least `2*HALF_DIV` clock cycles.
- R4: `mosi` changes only in the cycle in which `sclk` rises or `cs_n` falls. Frame bits go out most significant bit first, so the ADC latches bit 15 on the first SCLK falling edge.
- R5: `miso` is sampled on each SCLK rising edge, with the first rising edge giving result bit 15. `result` and a one-cycle `result_valid` are presented in the cycle in which `cs_n` returns high, and only for read frames.
- R6: After `run_en` goes high, the first frame is a configuration write `{4'hE, cfg}`, where `cfg` is `base_cfg` with bit `TRIG_BIT` set to 1 (1 = automatic trigger). Read frames `16'hD000` follow continuously.
- R7: A channel change sends three consecutive frames: `{4'hE, base_cfg with bit TRIG_BIT = 0}`, then the channel select `{1'b0, ch[2:0], 12'h000}` with the channel in bits 14:12, then `{4'hE, base_cfg with bit TRIG_BIT = 1}`. Read frames resume afterwards.
- R8: A change strobe that arrives while a frame is in flight is held. The frame in flight completes first, and the manual-trigger write is the very next frame. A strobe that arrives during a switch is served by a second full switch after the first one ends. Of several strobes, the latest channel wins.
- R9: No `result_valid` pulse occurs between the end of the manual-trigger write and the end of the automatic-trigger write.
- R10: When `run_en` falls, the frame in flight completes and no further frame starts. When `run_en` rises again, the configuration write of R6 is resent, using the current `base_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables frame generation |
| ch_req | input | CH_W | Channel to switch to, captured with the strobe |
| ch_change | input | 1 | One-cycle channel change request |
| base_cfg | input | 12 | Configuration bits; the trigger bit is overridden |
| sclk | output | 1 | Serial clock to the ADC, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command data to the ADC input |
| miso | input | 1 | Serial data from the ADC output |
| result | output | 16 | Last conversion word read |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
The bound checker enforces the frame-level rules on every cycle: the reset values, the SCLK idle level and high-phase length, 16 rising edges per chip-select window, the minimum chip-select high time, MOSI moving only on rising SCLK, and result strobes coinciding with the end of a frame. The command order can only be shown by scenarios. This covers the three-frame switch words, a strobe held behind a frame in flight, a strobe arriving mid-switch, the latest-channel rule, stop and restart, and the suspension of results during a switch. These run against a behavioural ADC that ignores channel selects while automatic triggering is on, so any switch that skips the trigger toggle returns data from the wrong channel.

// File: rtl/adc_chsw_pkg.sv
`timescale 1ns/1ps
package adc_chsw_pkg;
  localparam int FRAME_BITS = 16;
  localparam int CFG_BITS   = 12;
  localparam logic [3:0]  OP_CFG_WRITE = 4'hE;
  localparam logic [15:0] OP_READ_WORD = 16'hD000;

  typedef enum logic [2:0] {
    FK_NONE, FK_INIT, FK_READ, FK_MAN, FK_SEL, FK_AUTO
  } frame_kind_t;

  typedef enum logic [1:0] {ES_GAP, ES_IDLE, ES_XFER} eng_state_t;

  // Configuration-write frame with the trigger bit forced (1 = automatic).
  function automatic logic [FRAME_BITS-1:0] cfg_frame(
    input logic [CFG_BITS-1:0] base, input int pos, input logic auto_trig);
    logic [CFG_BITS-1:0] c;
    c      = base;
    c[pos] = auto_trig;
    return {OP_CFG_WRITE, c};
  endfunction
endpackage

// File: rtl/adc_chsw_tick.sv
`timescale 1ns/1ps
module adc_chsw_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || !en) cnt <= '0;
    else if (cnt == LAST)    cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  assign tick = en && !clear && (cnt == LAST);
endmodule

// File: rtl/adc_chsw_engine.sv
`timescale 1ns/1ps
module adc_chsw_engine
  import adc_chsw_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] tx_word,
  input  logic                  tx_is_read,
  output logic                  ready,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso,
  output logic [FRAME_BITS-1:0] rx_word,
  output logic                  rx_valid
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST_EDGE = BW'(FRAME_BITS - 1);

  eng_state_t            st;
  logic                  tick;
  logic                  launch;
  logic                  tick_en;
  logic                  last_edge;
  logic                  gap_half;
  logic                  tag;
  logic [BW-1:0]         edge_idx;
  logic [FRAME_BITS-1:0] tx_sh;
  logic [FRAME_BITS-1:0] rx_sh;

  assign ready   = (st == ES_IDLE);
  assign launch  = ready && start;
  assign tick_en = (st != ES_IDLE);

  adc_chsw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (launch),
    .en    (tick_en),
    .tick  (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ES_GAP;
      cs_n      <= 1'b1;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_word   <= '0;
      rx_valid  <= 1'b0;
      tag       <= 1'b0;
      edge_idx  <= '0;
      last_edge <= 1'b0;
      gap_half  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        ES_IDLE: begin
          if (start) begin
            st        <= ES_XFER;
            cs_n      <= 1'b0;
            sclk      <= 1'b0;
            mosi      <= tx_word[FRAME_BITS-1];
            tx_sh     <= tx_word;
            tag       <= tx_is_read;
            edge_idx  <= '0;
            last_edge <= 1'b0;
          end
        end
        ES_XFER: begin
          if (tick) begin
            if (last_edge) begin
              // one half period of hold after the final falling edge
              cs_n      <= 1'b1;
              last_edge <= 1'b0;
              rx_valid  <= tag;
              if (tag) rx_word <= rx_sh;
              st        <= ES_GAP;
              gap_half  <= 1'b0;
            end else if (!sclk) begin
              // rising edge: present next bit, capture ADC output
              sclk  <= 1'b1;
              mosi  <= tx_sh[FRAME_BITS-1];
              tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
              rx_sh <= {rx_sh[FRAME_BITS-2:0], miso};
            end else begin
              // falling edge: ADC latches mosi here
              sclk     <= 1'b0;
              edge_idx <= edge_idx + 1'b1;
              if (edge_idx == LAST_EDGE) last_edge <= 1'b1;
            end
          end
        end
        ES_GAP: begin
          if (tick) begin
            gap_half <= 1'b1;
            if (gap_half) st <= ES_IDLE;
          end
        end
        default: st <= ES_GAP;
      endcase
    end
  end
endmodule

// File: rtl/adc_chsw_sequencer.sv
`timescale 1ns/1ps
module adc_chsw_sequencer
  import adc_chsw_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int TRIG_BIT = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_en,
  input  logic                  ch_change,
  input  logic [CH_W-1:0]       ch_req,
  input  logic [CFG_BITS-1:0]   base_cfg,
  input  logic                  eng_ready,
  output logic                  start,
  output logic [FRAME_BITS-1:0] tx_word,
  output logic                  tx_is_read
);
  frame_kind_t           kind;
  logic                  need_init;
  logic                  pend;
  logic                  decide;
  logic                  take;
  logic [CH_W-1:0]       pend_ch;
  logic [CH_W-1:0]       sw_ch;
  logic [FRAME_BITS-1:0] w_auto;
  logic [FRAME_BITS-1:0] w_man;
  logic [FRAME_BITS-1:0] w_sel;

  always_comb begin
    w_auto = cfg_frame(base_cfg, TRIG_BIT, 1'b1);
    w_man  = cfg_frame(base_cfg, TRIG_BIT, 1'b0);
  end

  generate
    if (CH_W == 4) begin : g_sel_full
      assign w_sel = {sw_ch, {CFG_BITS{1'b0}}};
    end else begin : g_sel_pad
      assign w_sel = {{(4-CH_W){1'b0}}, sw_ch, {CFG_BITS{1'b0}}};
    end
  endgenerate

  assign decide = eng_ready && !start;
  assign take   = decide && run_en && !need_init && pend &&
                  (kind != FK_MAN) && (kind != FK_SEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      start      <= 1'b0;
      tx_word    <= '0;
      tx_is_read <= 1'b0;
      kind       <= FK_NONE;
      need_init  <= 1'b1;
      pend       <= 1'b0;
      pend_ch    <= '0;
      sw_ch      <= '0;
    end else begin
      start <= 1'b0;
      if (ch_change) begin
        pend    <= 1'b1;
        pend_ch <= ch_req;
      end else if (take) begin
        pend <= 1'b0;
      end

      if (decide) begin
        if (!run_en) begin
          need_init <= 1'b1;
        end else begin
          start      <= 1'b1;
          tx_is_read <= 1'b0;
          if (need_init) begin
            need_init <= 1'b0;
            kind      <= FK_INIT;
            tx_word   <= w_auto;
          end else if (kind == FK_MAN) begin
            kind    <= FK_SEL;
            tx_word <= w_sel;
          end else if (kind == FK_SEL) begin
            kind    <= FK_AUTO;
            tx_word <= w_auto;
          end else if (pend) begin
            kind    <= FK_MAN;
            tx_word <= w_man;
            sw_ch   <= pend_ch;
          end else begin
            kind       <= FK_READ;
            tx_word    <= OP_READ_WORD;
            tx_is_read <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_chsw_seq.sv
`timescale 1ns/1ps
module adc_chsw_seq
  import adc_chsw_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CH_W     = 3,
  parameter int TRIG_BIT = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run_en,
  input  logic [CH_W-1:0]       ch_req,
  input  logic                  ch_change,
  input  logic [CFG_BITS-1:0]   base_cfg,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso,
  output logic [FRAME_BITS-1:0] result,
  output logic                  result_valid
);
  logic                  eng_ready;
  logic                  start;
  logic                  tx_is_read;
  logic [FRAME_BITS-1:0] tx_word;

  adc_chsw_sequencer #(.CH_W(CH_W), .TRIG_BIT(TRIG_BIT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .run_en     (run_en),
    .ch_change  (ch_change),
    .ch_req     (ch_req),
    .base_cfg   (base_cfg),
    .eng_ready  (eng_ready),
    .start      (start),
    .tx_word    (tx_word),
    .tx_is_read (tx_is_read)
  );

  adc_chsw_engine #(.HALF_DIV(HALF_DIV)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tx_word    (tx_word),
    .tx_is_read (tx_is_read),
    .ready      (eng_ready),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .mosi       (mosi),
    .miso       (miso),
    .rx_word    (result),
    .rx_valid   (result_valid)
  );
endmodule

// File: rtl/adc_chsw_seq_chk.sv
`timescale 1ns/1ps
module adc_chsw_seq_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic result_valid
);
  logic        sclk_d;
  logic [15:0] hi_len;
  logic [15:0] high_ph;
  logic [5:0]  rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      hi_len  <= '0;
      high_ph <= '0;
      rises   <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n) hi_len <= (hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1;
      else      hi_len <= '0;
      if (sclk != sclk_d) high_ph <= 16'd1;
      else if (high_ph != 16'hFFFF) high_ph <= high_ph + 1'b1;
      if (cs_n) rises <= '0;
      else if (sclk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cs_n && !sclk && !result_valid));

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R2
  sclk_high_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_d && !sclk) |-> (high_ph == 16'(HALF_DIV)));

  // R2
  frame_rises_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (rises == 6'd16));

  // R3
  cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_len >= 16'(2*HALF_DIV)));

  // R4
  mosi_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !$stable(mosi)) |-> ($rose(sclk) || $fell(cs_n)));

  // R5
  result_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> $rose(cs_n));
endmodule

bind adc_chsw_seq adc_chsw_seq_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sclk         (sclk),
  .cs_n         (cs_n),
  .mosi         (mosi),
  .result_valid (result_valid)
);

// File: tb/adc_chsw_seq_test.sv
`timescale 1ns/1ps
module adc_chsw_seq_test;
  localparam int HALF   = 2;
  localparam int TRIG   = 9;
  localparam int NVEC   = 5;
  // {channel, base configuration}
  localparam logic [14:0] VEC [0:NVEC-1] = '{
    {3'd3, 12'h0FF}, {3'd7, 12'h000}, {3'd0, 12'hFFF},
    {3'd5, 12'h5A5}, {3'd1, 12'h123}};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [2:0]  ch_req = '0;
  logic        ch_change = 1'b0;
  logic [11:0] base_cfg = 12'h0FF;
  logic        sclk, cs_n, mosi, result_valid;
  logic        miso = 1'b0;
  logic [15:0] result;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  adc_chsw_seq #(.HALF_DIV(HALF), .CH_W(3), .TRIG_BIT(TRIG)) uut (
    .clk(clk), .rst(rst), .run_en(run_en), .ch_req(ch_req),
    .ch_change(ch_change), .base_cfg(base_cfg), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .result(result), .result_valid(result_valid));

  function automatic logic [15:0] conv(input logic [2:0] c);
    return 16'h0C3A + 16'(c) * 16'h1001;
  endfunction

  function automatic logic [15:0] cfg_word(input logic [11:0] b, input logic a);
    logic [11:0] c;
    c = b;
    c[TRIG] = a;
    return {4'hE, c};
  endfunction

  // ---- behavioural ADC ----
  logic [15:0] m_in, m_out;
  int          m_bits = 0;
  logic        m_auto = 1'b1;
  logic [2:0]  m_ch = '0;
  logic [15:0] log_w [0:255];
  int          res_at [0:255];
  int          log_n = 0;
  int          res_cnt = 0;
  int          bad_frames = 0;
  logic [15:0] last_res = '0;

  always @(negedge cs_n) begin
    m_out  = conv(m_ch);
    m_bits = 0;
    #1 miso = m_out[15];
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      m_in  = {m_in[14:0], mosi};
      m_bits++;
      m_out = {m_out[14:0], 1'b0};
      #1 miso = m_out[15];
    end
  end

  always @(posedge cs_n) begin
    if (!rst && log_n > 0 && m_bits != 16) bad_frames++;
    if (m_bits == 16) begin
      if (log_n < 256) begin
        log_w[log_n]  = m_in;
        res_at[log_n] = res_cnt;
        log_n++;
      end
      if (m_in[15:12] == 4'hE) m_auto = m_in[TRIG];
      else if (m_in[15] == 1'b0 && m_in[11:0] == 12'h000 && !m_auto)
        m_ch = m_in[14:12];
    end
    m_bits = 0;
  end

  // ---- result and chip-select monitors ----
  int hi_run = 0;
  int min_hi = 1000000;
  always @(negedge clk) begin
    if (result_valid === 1'b1) begin
      res_cnt++;
      last_res = result;
    end
    if (!rst) begin
      if (cs_n === 1'b1) hi_run++;
      else begin
        if (log_n > 0 && hi_run > 0 && hi_run < min_hi) min_hi = hi_run;
        hi_run = 0;
      end
    end
  end

  task automatic chk(input logic ok, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wait_log(input int n);
    while (log_n < n) @(negedge clk);
  endtask

  task automatic wait_res(input int n);
    while (res_cnt < n) @(negedge clk);
  endtask

  task automatic pulse(input logic [2:0] c);
    ch_req = c; ch_change = 1'b1;
    @(negedge clk);
    ch_change = 1'b0;
  endtask

  task automatic wait_cs_low();
    while (cs_n !== 1'b0) @(negedge clk);
  endtask

  task automatic run_switch(input logic [2:0] c, input logic [11:0] b);
    int idx;
    base_cfg = b;
    wait_cs_low();
    idx = log_n;
    pulse(c);
    wait_log(idx + 4);
    chk(log_w[idx] == 16'hD000, "R8 frame in flight completes first", log_w[idx], 16'hD000);
    chk(log_w[idx+1] == cfg_word(b, 1'b0), "R7 manual-trigger write", log_w[idx+1], cfg_word(b, 1'b0));
    chk(log_w[idx+2] == {1'b0, c, 12'h000}, "R7 channel select", log_w[idx+2], {1'b0, c, 12'h000});
    chk(log_w[idx+3] == cfg_word(b, 1'b1), "R7 auto-trigger write", log_w[idx+3], cfg_word(b, 1'b1));
    chk(res_at[idx+3] == res_at[idx+1], "R9 no result during switch",
        16'(res_at[idx+3]), 16'(res_at[idx+1]));
    wait_res(res_at[idx+3] + 1);
    chk(last_res == conv(c), "R5 result from new channel", last_res, conv(c));
  endtask

  initial begin
    int idx;
    repeat (5) @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n in reset", 16'(cs_n), 16'd1);
    chk(sclk === 1'b0, "R1 sclk in reset", 16'(sclk), 16'd0);
    chk(result_valid === 1'b0, "R1 result_valid in reset", 16'(result_valid), 16'd0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    chk(log_n == 0 && cs_n === 1'b1, "R1 no frame while run_en low", 16'(log_n), 16'd0);

    run_en = 1'b1;
    wait_log(2);
    chk(log_w[0] == cfg_word(12'h0FF, 1'b1), "R6 R4 initial configuration", log_w[0], cfg_word(12'h0FF, 1'b1));
    chk(log_w[1] == 16'hD000, "R6 read command", log_w[1], 16'hD000);
    wait_res(1);
    chk(last_res == conv(3'd0), "R5 R6 channel 0 result", last_res, conv(3'd0));

    for (int i = 0; i < NVEC; i++) run_switch(VEC[i][14:12], VEC[i][11:0]);

    // R8: strobe during a switch triggers a second switch
    base_cfg = 12'h0F0;
    wait_cs_low();
    idx = log_n;
    pulse(3'd2);
    wait_log(idx + 2);
    pulse(3'd6);
    wait_log(idx + 7);
    chk(log_w[idx+2] == 16'h2000, "R8 first select", log_w[idx+2], 16'h2000);
    chk(log_w[idx+3] == cfg_word(12'h0F0, 1'b1), "R8 first restore", log_w[idx+3], cfg_word(12'h0F0, 1'b1));
    chk(log_w[idx+4] == cfg_word(12'h0F0, 1'b0), "R8 second switch starts", log_w[idx+4], cfg_word(12'h0F0, 1'b0));
    chk(log_w[idx+5] == 16'h6000, "R8 second select", log_w[idx+5], 16'h6000);
    chk(log_w[idx+6] == cfg_word(12'h0F0, 1'b1), "R8 second restore", log_w[idx+6], cfg_word(12'h0F0, 1'b1));
    wait_res(res_at[idx+6] + 1);
    chk(last_res == conv(3'd6), "R8 result after double switch", last_res, conv(3'd6));

    // R8: two strobes within one frame, latest channel wins
    wait_cs_low();
    idx = log_n;
    pulse(3'd4);
    pulse(3'd1);
    wait_log(idx + 5);
    chk(log_w[idx+2] == 16'h1000, "R8 latest channel selected", log_w[idx+2], 16'h1000);
    chk(log_w[idx+4] == 16'hD000, "R8 single switch for merged strobes", log_w[idx+4], 16'hD000);

    // R10: stop and restart
    wait_cs_low();
    run_en = 1'b0;
    idx = log_n;
    wait_log(idx + 1);
    repeat (300) @(negedge clk);
    chk(log_n == idx + 1, "R10 no frame after stop", 16'(log_n), 16'(idx + 1));
    chk(cs_n === 1'b1, "R10 cs_n high while stopped", 16'(cs_n), 16'd1);
    base_cfg = 12'h400;
    run_en = 1'b1;
    wait_log(idx + 3);
    chk(log_w[idx+1] == cfg_word(12'h400, 1'b1), "R10 configuration resent", log_w[idx+1], cfg_word(12'h400, 1'b1));
    chk(log_w[idx+2] == 16'hD000, "R10 reads resume", log_w[idx+2], 16'hD000);

    chk(bad_frames == 0, "R2 frames of 16 clocks", 16'(bad_frames), 16'd0);
    chk(min_hi >= 2*HALF, "R3 chip-select high time", 16'(min_hi), 16'(2*HALF));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d expected %0d", log_n, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule